// File: doc/BRIEF.md
# Repeating Serial Chain Loader

This block loads long daisy-chained shift registers, such as the configuration chain of a pixel matrix. Software writes the outgoing bit stream into an internal byte memory over a simple single-master byte bus. It programs the chain length in bits, a repeat count and an idle gap, and then starts the transfer. The engine drives a serial clock, a data line and an active-high window enable. It captures the bits returned by the far end of the chain into a second memory, which software reads back.

A transfer starts from a bus write or from a pulse on an on-chip trigger input. The trigger only has effect while the trigger-enable bit is set. The whole sequence can run a set number of times, or keep running until software aborts it. A one-cycle load strobe marks the end of every pass so that the chain can latch what it received. Software polls a done bit to find out when the last pass has finished.

Top module: `shift_chain_engine`

## Requirements
- R1: After reset, sclk_o, sdo_o, sen_o and load_o are low. A read of address 0 returns VERSION (default 8'h21). A read of address 1 returns 1 in bit 0 (done).
- R2: Writes to the configuration registers read back unchanged: the bit count at addresses 3 (low byte) and 4 (high byte), the gap at addresses 5..8 (least significant byte first), trigger enable at address 9 bit 0, and the repeat count at address 10. Reads are registered, so data appears the cycle after the read strobe. Bytes written at address 16+k fill outgoing memory byte k.
- R3: The done bit (address 1, bit 0) reads 0 while a sequence runs and reads 1 once all passes have finished.
- R4: Each bit occupies two clock cycles, first with sclk_o low and then with sclk_o high. sen_o is high for the whole pass, and exactly `size` bits are sent per pass, whether or not `size` is a multiple of 8.
- R5: load_o pulses high for exactly one cycle right after each pass, in the first cycle in which sen_o is low.
- R6: Bit i is taken from outgoing byte i/8, bit 7-(i mod 8), so the MSB of byte 0 goes first. sdo_o changes only when sclk_o falls, or when a pass begins. sdi_i is sampled as sclk_o rises and is stored at the same position in the incoming memory, which is read at address 16+k. Bits at or beyond `size` are left unchanged.
- R7: A repeat count R of 1 or more gives exactly R passes. A count of 0 repeats without end. Between passes sen_o is low for wait+1 cycles.
- R8: A write to address 0 aborts any transfer at once: sen_o and sclk_o go low, done reads 1, and no further pass starts.
- R9: A pulse on ext_start_i starts a sequence only while trigger enable is 1. Any start, from the bus or the trigger, that arrives while a sequence is running is ignored.
- R10: A start with size 0 shifts nothing: sen_o stays low and done stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Read data, registered |
| ext_start_i | input | 1 | On-chip start trigger |
| sdi_i | input | 1 | Serial data returning from the chain |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the chain |
| sen_o | output | 1 | Shift window enable |
| load_o | output | 1 | One-cycle end-of-pass strobe |

## Verification
The assertions assume that bus strobes last a single cycle and are synchronous to clk_i. They also assume that the configuration registers stay unchanged while a sequence runs, because the engine reads size, gap and repeat count live. The stimulus writes configuration only while the engine is idle. During a run it issues only start, status reads and the abort, and it keeps `size` within the memory depth (MEM_BYTES*8 bits). sdi_i is fed from the inverse of sdo_o, so each captured bit has a known value that differs from the bit sent.

// File: rtl/shift_chain_pkg.sv
package shift_chain_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} seq_state_e;

  localparam int A_CTRL  = 0;   // write: abort, read: version
  localparam int A_START = 1;   // write: start, read bit0: done
  localparam int A_SIZE  = 3;   // bit count, low byte first
  localparam int A_WAIT  = 5;   // gap length, low byte first
  localparam int A_EN    = 9;   // trigger enable
  localparam int A_REP   = 10;  // repeat count, 0 = endless
  localparam int A_MEM   = 16;  // data memory window
endpackage

// File: rtl/shift_cfg_regs.sv
module shift_cfg_regs
  import shift_chain_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SIZE_W    = 16,
  parameter int WAIT_W    = 32,
  parameter int REP_W     = 8,
  parameter int MEM_BYTES = 16,
  parameter logic [7:0] VERSION = 8'h21,
  localparam int MAW = $clog2(MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              done_i,
  input  logic [7:0]        rx_rdata_i,
  output logic [7:0]        rdata_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [WAIT_W-1:0] wait_o,
  output logic [REP_W-1:0]  rep_o,
  output logic              en_o,
  output logic              start_o,
  output logic              abort_o,
  output logic              tx_we_o,
  output logic [MAW-1:0]    mem_idx_o
);
  localparam int SIZE_BYTES = SIZE_W / 8;
  localparam int WAIT_BYTES = WAIT_W / 8;

  logic in_mem;
  logic [7:0] rd_mux;
  logic [REP_W-1:0] rep_q;
  logic en_q;

  assign in_mem    = (addr_i >= ADDR_W'(A_MEM)) && (addr_i < ADDR_W'(A_MEM + MEM_BYTES));
  assign mem_idx_o = MAW'(addr_i - ADDR_W'(A_MEM));
  assign tx_we_o   = wr_i && in_mem;
  assign start_o   = wr_i && (addr_i == ADDR_W'(A_START));
  assign abort_o   = wr_i && (addr_i == ADDR_W'(A_CTRL));

  for (genvar b = 0; b < SIZE_BYTES; b++) begin : g_size
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) byte_q <= '0;
      else if (wr_i && addr_i == ADDR_W'(A_SIZE + b)) byte_q <= wdata_i;
    assign size_o[b*8 +: 8] = byte_q;
  end

  for (genvar b = 0; b < WAIT_BYTES; b++) begin : g_wait
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) byte_q <= '0;
      else if (wr_i && addr_i == ADDR_W'(A_WAIT + b)) byte_q <= wdata_i;
    assign wait_o[b*8 +: 8] = byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(A_REP)) rep_q <= REP_W'(wdata_i);
      if (addr_i == ADDR_W'(A_EN))  en_q  <= wdata_i[0];
    end
  end
  assign rep_o = rep_q;
  assign en_o  = en_q;

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(A_CTRL))       rd_mux = VERSION;
    else if (addr_i == ADDR_W'(A_START)) rd_mux = {7'b0, done_i};
    else if (addr_i == ADDR_W'(A_EN))    rd_mux = {7'b0, en_q};
    else if (addr_i == ADDR_W'(A_REP))   rd_mux = 8'(rep_q);
    else if (in_mem)                     rd_mux = rx_rdata_i;
    for (int b = 0; b < SIZE_BYTES; b++)
      if (addr_i == ADDR_W'(A_SIZE + b)) rd_mux = size_o[b*8 +: 8];
    for (int b = 0; b < WAIT_BYTES; b++)
      if (addr_i == ADDR_W'(A_WAIT + b)) rd_mux = wait_o[b*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
endmodule

// File: rtl/tx_bit_ram.sv
module tx_bit_ram #(
  parameter int MEM_BYTES = 16,
  localparam int MAW   = $clog2(MEM_BYTES),
  localparam int BIT_W = MAW + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [MAW-1:0]   waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [BIT_W-1:0] bidx_i,
  output logic             bit_o
);
  logic [7:0] mem [MEM_BYTES];

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) byte_q <= '0;
      else if (we_i && waddr_i == MAW'(g)) byte_q <= wdata_i;
    assign mem[g] = byte_q;
  end

  // MSB of each byte leaves first
  assign bit_o = mem[bidx_i[BIT_W-1:3]][~bidx_i[2:0]];
endmodule

// File: rtl/rx_bit_ram.sv
module rx_bit_ram #(
  parameter int MEM_BYTES = 16,
  localparam int MAW   = $clog2(MEM_BYTES),
  localparam int BIT_W = MAW + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [BIT_W-1:0] bidx_i,
  input  logic             bit_i,
  input  logic [MAW-1:0]   raddr_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem [MEM_BYTES];

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) byte_q <= '0;
      else if (we_i && bidx_i[BIT_W-1:3] == MAW'(g)) byte_q[~bidx_i[2:0]] <= bit_i;
    assign mem[g] = byte_q;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/shift_seq_core.sv
module shift_seq_core
  import shift_chain_pkg::*;
#(
  parameter int SIZE_W = 16,
  parameter int WAIT_W = 32,
  parameter int REP_W  = 8,
  parameter int BIT_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [REP_W-1:0]  rep_i,
  input  logic              tx_bit_i,
  input  logic              sdi_i,
  output logic [BIT_W-1:0]  tx_bidx_o,
  output logic              rx_we_o,
  output logic [BIT_W-1:0]  rx_bidx_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sen_o,
  output logic              load_o,
  output logic              done_o
);
  localparam logic [SIZE_W-1:0] S_ONE = SIZE_W'(1);
  localparam logic [REP_W-1:0]  R_ONE = REP_W'(1);

  seq_state_e        state_q;
  logic              phase_q;   // 0: sclk low half, 1: sclk high half
  logic [SIZE_W-1:0] idx_q;
  logic [WAIT_W-1:0] gap_q;
  logic [REP_W-1:0]  rep_left_q;
  logic              endless_q;

  // next bit to present on sdo: bit 0 on entry to a pass, else idx+1
  assign tx_bidx_o = (state_q == ST_SHIFT) ? BIT_W'(idx_q + S_ONE) : '0;
  assign rx_we_o   = (state_q == ST_SHIFT) && !phase_q;
  assign rx_bidx_o = BIT_W'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= 1'b0;
      idx_q      <= '0;
      gap_q      <= '0;
      rep_left_q <= '0;
      endless_q  <= 1'b0;
      sclk_o     <= 1'b0;
      sdo_o      <= 1'b0;
      sen_o      <= 1'b0;
      load_o     <= 1'b0;
      done_o     <= 1'b1;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      sclk_o  <= 1'b0;
      sdo_o   <= 1'b0;
      sen_o   <= 1'b0;
      load_o  <= 1'b0;
      done_o  <= 1'b1;
    end else begin
      load_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && size_i != '0) begin
            state_q    <= ST_SHIFT;
            phase_q    <= 1'b0;
            idx_q      <= '0;
            sen_o      <= 1'b1;
            sclk_o     <= 1'b0;
            sdo_o      <= tx_bit_i;
            done_o     <= 1'b0;
            endless_q  <= (rep_i == '0);
            rep_left_q <= rep_i;
          end
        end
        ST_SHIFT: begin
          if (!phase_q) begin
            sclk_o  <= 1'b1;
            phase_q <= 1'b1;
          end else begin
            sclk_o  <= 1'b0;
            phase_q <= 1'b0;
            if (idx_q == size_i - S_ONE) begin
              sen_o  <= 1'b0;
              load_o <= 1'b1;
              if (endless_q || rep_left_q > R_ONE) begin
                if (!endless_q) rep_left_q <= rep_left_q - R_ONE;
                gap_q   <= wait_i;
                state_q <= ST_GAP;
              end else begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
              end
            end else begin
              idx_q <= idx_q + S_ONE;
              sdo_o <= tx_bit_i;
            end
          end
        end
        ST_GAP: begin
          if (gap_q == '0) begin
            state_q <= ST_SHIFT;
            phase_q <= 1'b0;
            idx_q   <= '0;
            sen_o   <= 1'b1;
            sdo_o   <= tx_bit_i;
          end else begin
            gap_q <= gap_q - WAIT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shift_chain_engine.sv
module shift_chain_engine
  import shift_chain_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SIZE_W    = 16,
  parameter int WAIT_W    = 32,
  parameter int REP_W     = 8,
  parameter int MEM_BYTES = 16,
  parameter logic [7:0] VERSION = 8'h21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              ext_start_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sen_o,
  output logic              load_o
);
  localparam int MAW   = $clog2(MEM_BYTES);
  localparam int BIT_W = MAW + 3;

  logic [SIZE_W-1:0] size_w;
  logic [WAIT_W-1:0] wait_w;
  logic [REP_W-1:0]  rep_w;
  logic              en_w, sw_start, abort_w, tx_we, core_done, tx_bit, rx_we;
  logic [MAW-1:0]    mem_idx;
  logic [7:0]        rx_rdata;
  logic [BIT_W-1:0]  tx_bidx, rx_bidx;
  logic              start_w;

  assign start_w = sw_start || (en_w && ext_start_i);

  shift_cfg_regs #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WAIT_W(WAIT_W), .REP_W(REP_W),
    .MEM_BYTES(MEM_BYTES), .VERSION(VERSION)
  ) regs_i (
    .clk_i, .rst_ni,
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .done_i(core_done), .rx_rdata_i(rx_rdata), .rdata_o(bus_rdata_o),
    .size_o(size_w), .wait_o(wait_w), .rep_o(rep_w), .en_o(en_w),
    .start_o(sw_start), .abort_o(abort_w), .tx_we_o(tx_we), .mem_idx_o(mem_idx)
  );

  tx_bit_ram #(.MEM_BYTES(MEM_BYTES)) tx_ram_i (
    .clk_i, .rst_ni, .we_i(tx_we), .waddr_i(mem_idx), .wdata_i(bus_wdata_i),
    .bidx_i(tx_bidx), .bit_o(tx_bit)
  );

  rx_bit_ram #(.MEM_BYTES(MEM_BYTES)) rx_ram_i (
    .clk_i, .rst_ni, .we_i(rx_we), .bidx_i(rx_bidx), .bit_i(sdi_i),
    .raddr_i(mem_idx), .rdata_o(rx_rdata)
  );

  shift_seq_core #(
    .SIZE_W(SIZE_W), .WAIT_W(WAIT_W), .REP_W(REP_W), .BIT_W(BIT_W)
  ) core_i (
    .clk_i, .rst_ni, .start_i(start_w), .abort_i(abort_w),
    .size_i(size_w), .wait_i(wait_w), .rep_i(rep_w),
    .tx_bit_i(tx_bit), .sdi_i,
    .tx_bidx_o(tx_bidx), .rx_we_o(rx_we), .rx_bidx_o(rx_bidx),
    .sclk_o, .sdo_o, .sen_o, .load_o, .done_o(core_done)
  );
endmodule

// File: rtl/shift_chain_engine_chk.sv
module shift_chain_engine_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_o,
  input logic              sdo_o,
  input logic              sen_o,
  input logic              load_o,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              done_i
);
  a_r4_sclk_inside_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> sen_o);

  a_r5_load_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  a_r5_load_closes_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (!sen_o && $past(sen_o)));

  a_r3_busy_while_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_o |-> !done_i);

  a_r6_sdo_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sen_o && $past(sen_o) && !$stable(sdo_o)) |-> $fell(sclk_o));

  a_r8_abort_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == '0) |=> (!sen_o && !sclk_o && done_i));
endmodule

bind shift_chain_engine shift_chain_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .sdo_o(sdo_o), .sen_o(sen_o),
  .load_o(load_o), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .done_i(core_done)
);

// File: tb/shift_chain_engine_tb_top.sv
module shift_chain_engine_tb_top;
  timeunit 1ns; timeprecision 1ps;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] bus_addr_i = '0, bus_wdata_i = '0, bus_rdata_o;
  logic bus_wr_i = 1'b0, bus_rd_i = 1'b0, ext_start_i = 1'b0;
  logic sdi_i, sclk_o, sdo_o, sen_o, load_o;

  always #2.5 clk_i = ~clk_i;
  assign sdi_i = ~sdo_o;

  shift_chain_engine dut_i (.*);

  typedef struct { bit sen; bit sclk; bit load; int sdo; } exp_t;
  exp_t exp_q[$];
  logic [7:0] out_b [16];
  logic [7:0] exp_in [16];
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  task automatic report_end();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 100000", cycles);
      report_end();
    end
  end

  // per-cycle reference comparison
  always begin
    @(posedge clk_i); #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (sen_o !== e.sen || sclk_o !== e.sclk) begin
        errors++;
        $display("FAIL R4 framing: actual sen=%b sclk=%b expected sen=%b sclk=%b", sen_o, sclk_o, e.sen, e.sclk);
      end else if (load_o !== e.load) begin
        errors++;
        $display("FAIL R5 load: actual %b expected %b", load_o, e.load);
      end else if (e.sdo >= 0 && sdo_o !== e.sdo[0]) begin
        errors++;
        $display("FAIL R6 sdo: actual %b expected %0d", sdo_o, e.sdo);
      end
    end
  end

  function automatic bit out_bit(int i);
    return out_b[i/8][7 - i%8];
  endfunction

  // R4 R5 R7: expected waveform of a sequence, one entry per cycle
  task automatic push_run(int nbits, int reps, int wt, bit final_pass);
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < nbits; i++) begin
        exp_q.push_back('{sen: 1, sclk: 0, load: 0, sdo: int'(out_bit(i))});
        exp_q.push_back('{sen: 1, sclk: 1, load: 0, sdo: int'(out_bit(i))});
      end
      if (r < reps - 1 || !final_pass) begin
        for (int g = 0; g <= wt; g++)
          exp_q.push_back('{sen: 0, sclk: 0, load: (g == 0), sdo: -1});
      end else begin
        exp_q.push_back('{sen: 0, sclk: 0, load: 1, sdo: -1});
        exp_q.push_back('{sen: 0, sclk: 0, load: 0, sdo: -1});
      end
    end
  endtask

  task automatic apply_capture(int nbits);
    for (int i = 0; i < nbits; i++) exp_in[i/8][7 - i%8] = ~out_bit(i);
  endtask

  task automatic bus_write(int a, logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = 8'(a); bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic check_read(int a, logic [7:0] e, string tag);
    @(negedge clk_i);
    bus_addr_i = 8'(a); bus_rd_i = 1'b1;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
    checks++;
    if (bus_rdata_o !== e) begin
      errors++;
      $display("FAIL %s addr %0d: actual %h expected %h", tag, a, bus_rdata_o, e);
    end
  endtask

  task automatic sw_start_run(int nbits, int reps, int wt, bit final_pass);
    @(negedge clk_i);
    push_run(nbits, reps, wt, final_pass);
    bus_addr_i = 8'd1; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() > 0) @(negedge clk_i);
  endtask

  task automatic check_quiet(int n, string tag);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i); #1;
      if (sen_o !== 1'b0 || sclk_o !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: actual %0d active cycles expected 0", tag, bad);
    end
  endtask

  task automatic set_cfg(int sz, int wt, int rep);
    bus_write(3, 8'(sz)); bus_write(4, 8'(sz >> 8));
    for (int b = 0; b < 4; b++) bus_write(5 + b, 8'(wt >> (8*b)));
    bus_write(10, 8'(rep));
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      out_b[k] = 8'(8'h3C + 8'(37 * k));
      exp_in[k] = 8'h00;
    end
    out_b[2] = 8'h5A;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    checks++;
    if ({sclk_o, sdo_o, sen_o, load_o} !== 4'b0) begin
      errors++;
      $display("FAIL R1 idle outputs: actual %b expected 0000", {sclk_o, sdo_o, sen_o, load_o});
    end
    check_read(0, 8'h21, "R1 version");
    check_read(1, 8'h01, "R1 done");

    for (int k = 0; k < 16; k++) bus_write(16 + k, out_b[k]);
    set_cfg(20, 32'h0000_0003, 2);
    check_read(3, 8'd20, "R2 size lo");
    check_read(4, 8'd0, "R2 size hi");
    check_read(5, 8'd3, "R2 wait b0");
    check_read(10, 8'd2, "R2 repeat");
    bus_write(9, 8'h01);
    check_read(9, 8'h01, "R2 enable");
    bus_write(9, 8'h00);
    check_read(9, 8'h00, "R2 enable clear");
    check_read(16, 8'h00, "R2 capture memory at reset");

    // two passes of 20 bits, a start while busy is ignored
    sw_start_run(20, 2, 3, 1);
    repeat (4) @(negedge clk_i);
    check_read(1, 8'h00, "R3 done while running");
    bus_write(1, 8'h00);  // R9 ignored while busy
    wait_drain();
    check_read(1, 8'h01, "R3 done after last pass");
    apply_capture(20);
    for (int k = 0; k < 4; k++) check_read(16 + k, exp_in[k], "R6 captured byte");

    // one pass, byte aligned, no gap
    set_cfg(8, 0, 1);
    sw_start_run(8, 1, 0, 1);
    wait_drain();
    apply_capture(8);
    check_read(16, exp_in[0], "R6 byte aligned capture");
    check_read(17, exp_in[1], "R6 untouched beyond size");

    // trigger gated by enable
    set_cfg(13, 1, 3);
    @(negedge clk_i); ext_start_i = 1'b1;
    @(negedge clk_i); ext_start_i = 1'b0;
    check_quiet(10, "R9 trigger ignored when disabled");
    bus_write(9, 8'h01);
    @(negedge clk_i);
    push_run(13, 3, 1, 1);
    ext_start_i = 1'b1;
    @(negedge clk_i); ext_start_i = 1'b0;
    wait_drain();
    check_read(1, 8'h01, "R9 triggered sequence finished");
    apply_capture(13);
    check_read(17, exp_in[1], "R6 capture after trigger run");
    bus_write(9, 8'h00);

    // zero length
    set_cfg(0, 0, 1);
    bus_write(1, 8'h00);
    check_quiet(10, "R10 size zero shifts nothing");
    check_read(1, 8'h01, "R10 done stays set");

    // endless repeat, then abort
    set_cfg(8, 2, 0);
    sw_start_run(8, 3, 2, 0);
    wait_drain();
    check_read(1, 8'h00, "R7 endless still running");
    bus_write(0, 8'h00);
    checks++;
    if (sen_o !== 1'b0 || sclk_o !== 1'b0) begin
      errors++;
      $display("FAIL R8 abort: actual sen=%b sclk=%b expected 0 0", sen_o, sclk_o);
    end
    check_quiet(12, "R8 no pass after abort");
    check_read(1, 8'h01, "R8 done after abort");
    apply_capture(8);
    check_read(16, exp_in[0], "R6 capture after endless run");

    report_end();
  end
endmodule